// File: doc/BRIEF.md
# Fault Classifier and Trap Parameter Generator

This block decides what to do with a fault once the error status has been latched. A one-cycle start pulse captures the error flags: stack overflow, control-store parity, register-file parity, memory error, and the memory detail flags for out-of-bounds, bus parity, storage-stage A/B and map-stage A/B. It also captures three policy bits from a 16-bit configuration word, the map dirty flag, the faulting virtual page, the reference type and the current task number. One cycle later the block registers its verdict. The verdict is an action code, plus a crash code, a sign-encoded trap parameter, a notify-target select and a tag, each used by one of the actions.

The trap parameter lets the downstream handler tell the three kinds of map trouble apart from the sign and top bits alone. Out-of-bounds gives all ones. A write-protect fault is negative with the page in the low bits. A page fault is positive with the page in the low bits. The surrounding sequencer uses the notify target to choose between the emulator's fault entry and the entry for an interrupted non-emulator task.

Top module: `fault_classifier`

## Requirements
- R1: A start pulse sampled while idle raises busy for exactly one cycle. In the next cycle busy is low and result_valid is high for one cycle, carrying the verdict for the captured inputs.
- R2: A start pulse sampled while busy is high is ignored: the pending verdict is unchanged and no further result_valid pulse follows.
- R3: Either parity error (control store or register file) always yields action CRASH (code 0) with crash code 0x02, whatever the other flags and configuration bits are.
- R4: Without parity errors, a memory error is handled before a stack overflow. When both are present, the memory-error verdict is produced.
- R5: A memory error with the out-of-bounds flag and no bus parity flag gives NOTIFY (action 1) with trap parameter 0xFFFF when config bit 15 is 1. When config bit 15 is 0 it gives CRASH with code 0x09.
- R6: A memory error with the bus parity flag (with or without out-of-bounds) gives IGNORE (action 3) when config bit 2 is 0, and CRASH with code 0x08 when it is 1.
- R7: Otherwise, a single storage-stage error (A or B, taken before any map-stage flag) gives RESUME (action 2) when config bit 0 is 1, and CRASH with code 0x05 when it is 0.
- R8: Storage-stage errors on both A and B give CRASH code 0x06. A memory error with no detail flag set gives CRASH code 0x07.
- R9: Otherwise, a map-stage error with config bit 15 set gives NOTIFY. The trap parameter is {2'b00, page} when the dirty flag is 1 (page fault) and {2'b10, page} when it is 0 (write-protect). With bit 15 clear the verdict is CRASH code 0x04.
- R10: A stack overflow with no memory or parity error gives NOTIFY with trap parameter 0 when config bit 15 is 1, and CRASH code 0x03 when it is 0.
- R11: On NOTIFY, notify_emu is 1 if the captured task number is 0 and 0 otherwise. For any other action it is 0.
- R12: On NOTIFY the tag is {1'b0, ref_type} for memory faults and 5'b10000 for a stack error. It is 0 for other actions. The crash code is 0 for every action but CRASH, and the trap parameter is 0 outside memory NOTIFY.
- R13: With no error flag set at all, the verdict is CRASH code 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin classification |
| err_stack | input | 1 | Stack overflow/underflow latched |
| err_cs_parity | input | 1 | Control-store parity error |
| err_rm_parity | input | 1 | Register-file parity error |
| err_mem | input | 1 | Memory error summary flag |
| mem_oob | input | 1 | Address out of bounds |
| mem_bus_parity | input | 1 | Bus parity error |
| sto_err_a | input | 1 | Storage-stage error, pipe A |
| sto_err_b | input | 1 | Storage-stage error, pipe B |
| map_err_a | input | 1 | Map-stage error, pipe A |
| map_err_b | input | 1 | Map-stage error, pipe B |
| map_dirty | input | 1 | Map dirty flag (1 = page fault, 0 = write-protect) |
| vpage | input | 14 | Faulting virtual page |
| ref_type | input | 4 | Reference type of the faulting access |
| task_id | input | 4 | Task current when the fault began |
| cfg | input | 16 | Configuration word (bits 0, 2, 15 used) |
| busy | output | 1 | Classification in progress |
| result_valid | output | 1 | Verdict valid this cycle |
| action | output | 2 | 0 crash, 1 notify, 2 resume, 3 ignore |
| crash_code | output | 8 | Crash code when action is crash |
| trap_param | output | 16 | Sign-encoded trap parameter |
| notify_emu | output | 1 | 1 selects the emulator notify entry |
| fault_tag | output | 5 | Reference-type or stack-error tag |

## Verification
The assertions assume that start arrives as a level sampled on the clock edge and that the input flags are steady in the cycle start is sampled. They also assume the captured state is not rewritten between capture and verdict, which R2 guarantees. The stimulus drives every input away from the clock edge and changes them only together with start. Random draws weight the flags so that each priority branch is reached often, and directed cases cover page 0x3FFF, both storage pipes, an empty memory error and a start pulse issued while busy.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int TASK_W = 4;
    localparam int REF_W  = 4;
    localparam int PAGE_W = 14;
    localparam int PARM_W = PAGE_W + 2;
    localparam int CODE_W = 8;
    localparam int CFG_W  = 16;
    localparam int TAG_W  = REF_W + 1;

    localparam int CFG_RESUME = 0;
    localparam int CFG_BUSPAR = 2;
    localparam int CFG_NOTIFY = 15;

    typedef enum logic [1:0] {
        ACT_CRASH  = 2'd0,
        ACT_NOTIFY = 2'd1,
        ACT_RESUME = 2'd2,
        ACT_IGNORE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        TP_NONE  = 2'd0,
        TP_OOB   = 2'd1,
        TP_PAGE  = 2'd2,
        TP_WPROT = 2'd3
    } tp_e;

    localparam logic [CODE_W-1:0] CC_NONE     = 8'h00;
    localparam logic [CODE_W-1:0] CC_BREAK    = 8'h01;
    localparam logic [CODE_W-1:0] CC_PARITY   = 8'h02;
    localparam logic [CODE_W-1:0] CC_STACK    = 8'h03;
    localparam logic [CODE_W-1:0] CC_MAP      = 8'h04;
    localparam logic [CODE_W-1:0] CC_STO      = 8'h05;
    localparam logic [CODE_W-1:0] CC_STO_BOTH = 8'h06;
    localparam logic [CODE_W-1:0] CC_MEM_NONE = 8'h07;
    localparam logic [CODE_W-1:0] CC_BUSPAR   = 8'h08;
    localparam logic [CODE_W-1:0] CC_OOB      = 8'h09;

    typedef struct packed {
        logic              stk;
        logic              cs_par;
        logic              rm_par;
        logic              mem;
        logic              oob;
        logic              bus_par;
        logic              sto_a;
        logic              sto_b;
        logic              map_a;
        logic              map_b;
        logic              dirty;
        logic [PAGE_W-1:0] page;
        logic [REF_W-1:0]  rtype;
        logic [TASK_W-1:0] task_id;
        logic              pol_resume;
        logic              pol_buspar;
        logic              pol_notify;
    } cap_t;

    typedef struct packed {
        act_e              act;
        logic [CODE_W-1:0] code;
        logic [PARM_W-1:0] parm;
        logic              emu;
        logic [TAG_W-1:0]  tag;
    } res_t;
endpackage

// File: rtl/fc_trap_param.sv
module fc_trap_param
    import fc_pkg::*;
#(
    parameter int PG_W = PAGE_W,
    localparam int PM_W = PG_W + 2
) (
    input  tp_e             kind,
    input  logic [PG_W-1:0] page,
    output logic [PM_W-1:0] parm
);
    always_comb begin
        unique case (kind)
            TP_OOB:   parm = '1;
            TP_PAGE:  parm = {2'b00, page};
            TP_WPROT: parm = {2'b10, page};
            default:  parm = '0;
        endcase
    end
endmodule

// File: rtl/fc_classify.sv
module fc_classify
    import fc_pkg::*;
(
    input  cap_t              c,
    output act_e              act,
    output logic [CODE_W-1:0] code,
    output tp_e               kind,
    output logic              emu,
    output logic [TAG_W-1:0]  tag
);
    logic [TAG_W-1:0] mem_tag;
    localparam logic [TAG_W-1:0] STACK_TAG = {1'b1, {REF_W{1'b0}}};

    assign mem_tag = {1'b0, c.rtype};

    always_comb begin
        act  = ACT_CRASH;
        code = CC_NONE;
        kind = TP_NONE;
        tag  = '0;
        if (c.cs_par || c.rm_par) begin
            code = CC_PARITY;
        end else if (c.mem) begin
            if (c.bus_par) begin
                if (c.pol_buspar) code = CC_BUSPAR;
                else              act  = ACT_IGNORE;
            end else if (c.oob) begin
                if (c.pol_notify) begin
                    act  = ACT_NOTIFY;
                    kind = TP_OOB;
                    tag  = mem_tag;
                end else begin
                    code = CC_OOB;
                end
            end else if (c.sto_a && c.sto_b) begin
                code = CC_STO_BOTH;
            end else if (c.sto_a || c.sto_b) begin
                if (c.pol_resume) act  = ACT_RESUME;
                else              code = CC_STO;
            end else if (c.map_a || c.map_b) begin
                if (c.pol_notify) begin
                    act  = ACT_NOTIFY;
                    kind = c.dirty ? TP_PAGE : TP_WPROT;
                    tag  = mem_tag;
                end else begin
                    code = CC_MAP;
                end
            end else begin
                code = CC_MEM_NONE;
            end
        end else if (c.stk) begin
            if (c.pol_notify) begin
                act = ACT_NOTIFY;
                tag = STACK_TAG;
            end else begin
                code = CC_STACK;
            end
        end else begin
            code = CC_BREAK;
        end
        emu = (act == ACT_NOTIFY) && (c.task_id == '0);
    end
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              err_stack,
    input  logic              err_cs_parity,
    input  logic              err_rm_parity,
    input  logic              err_mem,
    input  logic              mem_oob,
    input  logic              mem_bus_parity,
    input  logic              sto_err_a,
    input  logic              sto_err_b,
    input  logic              map_err_a,
    input  logic              map_err_b,
    input  logic              map_dirty,
    input  logic [13:0]       vpage,
    input  logic [3:0]        ref_type,
    input  logic [3:0]        task_id,
    input  logic [15:0]       cfg,
    output logic              busy,
    output logic              result_valid,
    output logic [1:0]        action,
    output logic [7:0]        crash_code,
    output logic [15:0]       trap_param,
    output logic              notify_emu,
    output logic [4:0]        fault_tag
);
    typedef struct packed {
        logic busy;
        logic valid;
        cap_t cap;
        res_t res;
    } state_t;

    state_t            st_q, st_d;
    cap_t              cap_in;
    act_e              cl_act;
    logic [CODE_W-1:0] cl_code;
    tp_e               cl_kind;
    logic              cl_emu;
    logic [TAG_W-1:0]  cl_tag;
    logic [PARM_W-1:0] tp_parm;
    logic              accept;

    always_comb begin
        cap_in.stk        = err_stack;
        cap_in.cs_par     = err_cs_parity;
        cap_in.rm_par     = err_rm_parity;
        cap_in.mem        = err_mem;
        cap_in.oob        = mem_oob;
        cap_in.bus_par    = mem_bus_parity;
        cap_in.sto_a      = sto_err_a;
        cap_in.sto_b      = sto_err_b;
        cap_in.map_a      = map_err_a;
        cap_in.map_b      = map_err_b;
        cap_in.dirty      = map_dirty;
        cap_in.page       = vpage;
        cap_in.rtype      = ref_type;
        cap_in.task_id    = task_id;
        cap_in.pol_resume = cfg[CFG_RESUME];
        cap_in.pol_buspar = cfg[CFG_BUSPAR];
        cap_in.pol_notify = cfg[CFG_NOTIFY];
    end

    fc_classify i_classify (
        .c    (st_q.cap),
        .act  (cl_act),
        .code (cl_code),
        .kind (cl_kind),
        .emu  (cl_emu),
        .tag  (cl_tag)
    );

    fc_trap_param #(.PG_W(PAGE_W)) i_trap_param (
        .kind (cl_kind),
        .page (st_q.cap.page),
        .parm (tp_parm)
    );

    assign accept = start && !st_q.busy;

    always_comb begin
        st_d       = st_q;
        st_d.busy  = accept;
        st_d.valid = st_q.busy;
        if (accept) st_d.cap = cap_in;
        if (st_q.busy) begin
            st_d.res.act  = cl_act;
            st_d.res.code = cl_code;
            st_d.res.parm = tp_parm;
            st_d.res.emu  = cl_emu;
            st_d.res.tag  = cl_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy         = st_q.busy;
    assign result_valid = st_q.valid;
    assign action       = st_q.res.act;
    assign crash_code   = st_q.res.code;
    assign trap_param   = st_q.res.parm;
    assign notify_emu   = st_q.res.emu;
    assign fault_tag    = st_q.res.tag;

    p_busy_then_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (result_valid && !busy));

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.cap) && !busy));

    p_parity_crash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && (st_q.cap.cs_par || st_q.cap.rm_par))
        |-> (action == ACT_CRASH && crash_code == CC_PARITY));

    p_wprot_top_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && action == ACT_NOTIFY && trap_param[PARM_W-1] && !(&trap_param))
        |-> !trap_param[PARM_W-2]);

    p_emu_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (notify_emu == (action == ACT_NOTIFY && st_q.cap.task_id == '0)));

    p_stack_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && fault_tag[TAG_W-1]) |-> (action == ACT_NOTIFY && trap_param == '0));

    p_code_only_on_crash_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && action != ACT_CRASH) |-> (crash_code == CC_NONE));
endmodule

// File: tb/test_fault_classifier.sv
module test_fault_classifier;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic err_stack = 0, err_cs_parity = 0, err_rm_parity = 0, err_mem = 0;
    logic mem_oob = 0, mem_bus_parity = 0, sto_err_a = 0, sto_err_b = 0;
    logic map_err_a = 0, map_err_b = 0, map_dirty = 0;
    logic [13:0] vpage = '0;
    logic [3:0]  ref_type = '0, task_id = '0;
    logic [15:0] cfg = '0;
    logic        busy, result_valid, notify_emu;
    logic [1:0]  action;
    logic [7:0]  crash_code;
    logic [15:0] trap_param;
    logic [4:0]  fault_tag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    fault_classifier i_fault_classifier (
        .clk(clk), .rst_n(rst_n), .start(start),
        .err_stack(err_stack), .err_cs_parity(err_cs_parity), .err_rm_parity(err_rm_parity),
        .err_mem(err_mem), .mem_oob(mem_oob), .mem_bus_parity(mem_bus_parity),
        .sto_err_a(sto_err_a), .sto_err_b(sto_err_b), .map_err_a(map_err_a), .map_err_b(map_err_b),
        .map_dirty(map_dirty), .vpage(vpage), .ref_type(ref_type), .task_id(task_id), .cfg(cfg),
        .busy(busy), .result_valid(result_valid), .action(action), .crash_code(crash_code),
        .trap_param(trap_param), .notify_emu(notify_emu), .fault_tag(fault_tag)
    );

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected verdict {action, code, param, emu, tag} from the requirements.
    function automatic logic [31:0] model();
        logic [1:0] a; logic [7:0] c; logic [15:0] p; logic e; logic [4:0] t;
        a = 2'd0; c = 8'h00; p = 16'h0; t = 5'h0;
        if (err_cs_parity || err_rm_parity) c = 8'h02;              // R3
        else if (err_mem) begin                                     // R4
            if (mem_bus_parity) begin                               // R6
                if (cfg[2]) c = 8'h08; else a = 2'd3;
            end else if (mem_oob) begin                             // R5
                if (cfg[15]) begin a = 2'd1; p = 16'hFFFF; t = {1'b0, ref_type}; end
                else c = 8'h09;
            end else if (sto_err_a && sto_err_b) c = 8'h06;         // R8
            else if (sto_err_a || sto_err_b) begin                  // R7
                if (cfg[0]) a = 2'd2; else c = 8'h05;
            end else if (map_err_a || map_err_b) begin              // R9
                if (cfg[15]) begin
                    a = 2'd1; t = {1'b0, ref_type};
                    p = map_dirty ? {2'b00, vpage} : {2'b10, vpage};
                end else c = 8'h04;
            end else c = 8'h07;                                     // R8
        end else if (err_stack) begin                               // R10
            if (cfg[15]) begin a = 2'd1; t = 5'b10000; end else c = 8'h03;
        end else c = 8'h01;                                         // R13
        e = (a == 2'd1) && (task_id == 4'd0);                       // R11
        return {a, c, p, e, t};
    endfunction

    task automatic clear_in();
        {err_stack, err_cs_parity, err_rm_parity, err_mem, mem_oob, mem_bus_parity} = '0;
        {sto_err_a, sto_err_b, map_err_a, map_err_b, map_dirty} = '0;
        vpage = '0; ref_type = '0; task_id = '0; cfg = '0;
    endtask

    // Issue one start at a negedge, then check at the following negedges.
    task automatic run(input string req);
        logic [31:0] exp;
        exp = model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R1 busy"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk({req, " R1 valid"}, {30'd0, result_valid, busy}, 32'd2);
        chk({req, " R12 verdict"}, {action, crash_code, trap_param, notify_emu, fault_tag}, exp);
    endtask

    task automatic rand_in();
        clear_in();
        err_cs_parity  = ($urandom % 10) == 0;
        err_rm_parity  = ($urandom % 10) == 0;
        err_mem        = ($urandom % 3) != 0;
        err_stack      = ($urandom % 3) == 0;
        mem_oob        = ($urandom % 5) == 0;
        mem_bus_parity = ($urandom % 6) == 0;
        sto_err_a      = ($urandom % 5) == 0;
        sto_err_b      = ($urandom % 5) == 0;
        map_err_a      = ($urandom % 3) == 0;
        map_err_b      = ($urandom % 4) == 0;
        map_dirty      = $urandom % 2;
        vpage          = 14'($urandom);
        ref_type       = 4'($urandom);
        task_id        = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
        cfg            = 16'($urandom);
    endtask

    initial begin
        logic [31:0] exp;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 reset busy/valid", {30'd0, busy, result_valid}, 32'd0);
        chk("R12 reset outputs", {action, crash_code, trap_param, notify_emu, fault_tag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        clear_in(); run("R13 no flags");
        clear_in(); err_cs_parity = 1; err_mem = 1; mem_oob = 1; cfg = 16'hFFFF; run("R3 cs parity");
        clear_in(); err_rm_parity = 1; err_stack = 1; cfg = 16'h8000; run("R3 rm parity");
        clear_in(); err_mem = 1; err_stack = 1; map_err_a = 1; map_dirty = 1; cfg = 16'h8000;
        vpage = 14'h0123; ref_type = 4'h5; task_id = 4'd0; run("R4 mem before stack");
        clear_in(); err_mem = 1; mem_oob = 1; cfg = 16'h8000; task_id = 4'd3; ref_type = 4'hA; run("R5 oob notify");
        clear_in(); err_mem = 1; mem_oob = 1; run("R5 oob crash");
        clear_in(); err_mem = 1; mem_bus_parity = 1; mem_oob = 1; cfg = 16'h8000; run("R6 bus parity ignored");
        clear_in(); err_mem = 1; mem_bus_parity = 1; cfg = 16'h0004; run("R6 bus parity crash");
        clear_in(); err_mem = 1; sto_err_b = 1; map_err_a = 1; cfg = 16'h8001; run("R7 storage resume");
        clear_in(); err_mem = 1; sto_err_a = 1; run("R7 storage crash");
        clear_in(); err_mem = 1; sto_err_a = 1; sto_err_b = 1; cfg = 16'hFFFF; run("R8 both pipes");
        clear_in(); err_mem = 1; cfg = 16'hFFFF; run("R8 empty memory error");
        clear_in(); err_mem = 1; map_err_b = 1; map_dirty = 0; vpage = 14'h3FFF; cfg = 16'h8000; run("R9 wprot top page");
        chk("R9 wprot distinct from oob", {16'd0, trap_param}, 32'h0000BFFF);
        clear_in(); err_mem = 1; map_err_a = 1; map_dirty = 1; vpage = 14'h3FFF; cfg = 16'h8000; run("R9 page fault");
        clear_in(); err_mem = 1; map_err_a = 1; run("R9 map crash");
        clear_in(); err_stack = 1; cfg = 16'h8000; task_id = 4'd7; run("R10 stack notify R11 non-emu");
        clear_in(); err_stack = 1; cfg = 16'h8000; task_id = 4'd0; run("R10 stack notify R11 emu");
        clear_in(); err_stack = 1; cfg = 16'h7FFF; run("R10 stack crash");

        // R2: a second start while busy must be ignored.
        clear_in(); err_mem = 1; sto_err_a = 1; sto_err_b = 1;
        exp = model();
        start = 1'b1;
        @(negedge clk);
        chk("R2 busy", {31'd0, busy}, 32'd1);
        clear_in(); err_stack = 1; cfg = 16'h8000;
        @(negedge clk);
        start = 1'b0;
        chk("R2 first verdict kept", {action, crash_code, trap_param, notify_emu, fault_tag}, exp);
        @(negedge clk);
        chk("R2 no second result", {30'd0, result_valid, busy}, 32'd0);
        chk("R2 verdict unchanged", {action, crash_code, trap_param, notify_emu, fault_tag}, exp);

        for (int i = 0; i < 400; i++) begin
            rand_in();
            run("R4 random");
            if ($urandom % 2) @(negedge clk);
        end
        summary_and_end();
    end
endmodule